// File: doc/BRIEF.md
# Counted-Burst PWM Generator with Shadowed Compare

This block is a single-channel up-counting PWM timer that sends out a burst of a chosen number of periods and then parks its pin at a defined idle level. A counter steps from zero up to a reload value, wraps to zero, and signals an update event at the wrap. During a burst the pin carries the internal reference. The reference is active while the counter is below the active compare value. The output stage applies a selectable polarity after that decision and can be disabled, in which case it drives the idle level.

Compare and reload writes can be held in shadow registers until an update event. The polarity is applied after the active/inactive decision. Together these two rules give a stable, known pin level before the first burst, between bursts and after the last period. The same level appears whether or not the channel has ever run. Software configures the block through a small address/data write port. It then pulses `start`, and it watches `done` or the per-update `updateFlag`. A separate `swUpdate` strobe moves shadow values into use without waiting for a wrap.

Top module: `pwm_burst_gen`

## Requirements
- R1: While a burst runs, the counter advances by one each cycle from 0 to the active reload value and then returns to 0. A period is therefore reload+1 cycles. `updateFlag` is high for the one cycle that follows each wrap.
- R2: During a burst the reference is active exactly when counter < active compare, compared unsigned. A compare of 0 keeps the reference inactive for the whole burst. A compare above the reload keeps it active for the whole burst.
- R3: With the output enabled, the pin equals the reference XOR the polarity bit. The polarity bit is config bit 0, and 1 means active-low. With the output disabled (config bit 2 = 0), or while no burst runs, the pin equals the polarity bit.
- R4: Writes go to address 0 for reload, 1 for compare, 2 for config and 3 for pulse count. With preload on (config bit 1 = 1), a compare write is held and takes effect only at the next update event. With preload off it takes effect in the cycle after the write. Reload writes are always held until an update event.
- R5: A `start` pulse while idle, with a nonzero pulse count, does four things. It copies the held reload and compare into use, resets the counter to 0 and begins the burst. It also raises `updateFlag` for one cycle. Counter value 0 appears in the cycle right after the start pulse.
- R6: A burst of N pulses lasts N full periods. In the cycle after the N-th wrap, `running` is low and `done` is high for exactly one cycle. The pin is then at its idle level.
- R7: A `start` pulse during a burst has no effect, even after the pulse count register has been rewritten. A `start` pulse with a pulse count of 0 is also ignored.
- R8: A `swUpdate` pulse copies the held reload and compare into use, resets the counter to 0 and raises `updateFlag`. The period it cuts short is not counted as a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 reload, 1 compare, 2 config, 3 pulse count) |
| wrData | input | CNT_W | Write data |
| start | input | 1 | Burst start strobe |
| swUpdate | input | 1 | Forced update strobe |
| pwmOut | output | 1 | PWM pin level |
| running | output | 1 | High while a burst is in progress |
| done | output | 1 | One-cycle pulse after the last period |
| updateFlag | output | 1 | One-cycle pulse after every update event |

## Verification
Every result is registered once. The cycle after a `start` pulse is therefore offset 0 of the burst, with the counter at 0 and `updateFlag` high. The pin at offset t follows from t modulo the period, `updateFlag` rises at offsets that are multiples of reload+1, and `done` appears at offset N*(reload+1). A non-preloaded compare write in cycle t shows on the pin from t+1. A preloaded write shows from the next wrap or forced update, and a `swUpdate` in cycle t puts the counter at 0 in cycle t+1. The bench computes each of these offsets from the burst parameters. It samples at the falling edge, one offset per cycle, and compares the pin, `updateFlag`, `done` and `running` in every cycle of each burst.

// File: rtl/pwm_burst_pkg.sv
`timescale 1ns/1ps
package pwm_burst_pkg;
  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_CMP    = 2'd1;
  localparam logic [1:0] ADDR_CFG    = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic forceUpd;  // copy shadows into use, clear counter
    logic run;       // counter advances, reference may go active
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_burst_dp.sv
`timescale 1ns/1ps
module pwm_burst_dp
  import pwm_burst_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  ctrlStrobe_t        ctrl,
  output logic               wrap,
  output logic [PULSE_W-1:0] pulseCfg,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   cmpAct,
  output logic               preloadOn,
  output logic               polLow,
  output logic               pwmOut,
  output logic               updateFlag
);
  logic [CNT_W-1:0] arrShadow, arrAct, cmpShadow;
  logic [CNT_W-1:0] arrShadowNxt, cmpShadowNxt;
  logic             outEn;
  logic             arrWr, cmpWr, cfgWr, cntWr;
  logic             refActive;

  always_comb begin
    arrWr = wrEn && (wrAddr == ADDR_PERIOD);
    cmpWr = wrEn && (wrAddr == ADDR_CMP);
    cfgWr = wrEn && (wrAddr == ADDR_CFG);
    cntWr = wrEn && (wrAddr == ADDR_COUNT);
  end

  assign arrShadowNxt = arrWr ? wrData : arrShadow;
  assign cmpShadowNxt = cmpWr ? wrData : cmpShadow;

  assign wrap = ctrl.run && (cnt == arrAct);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arrShadow  <= '0;
      arrAct     <= '0;
      cmpShadow  <= '0;
      cmpAct     <= '0;
      pulseCfg   <= '0;
      outEn      <= 1'b0;
      preloadOn  <= 1'b0;
      polLow     <= 1'b0;
      cnt        <= '0;
      updateFlag <= 1'b0;
    end else begin
      arrShadow <= arrShadowNxt;
      cmpShadow <= cmpShadowNxt;
      if (cfgWr) begin
        polLow    <= wrData[0];
        preloadOn <= wrData[1];
        outEn     <= wrData[2];
      end
      if (cntWr) pulseCfg <= wrData[PULSE_W-1:0];

      if (ctrl.forceUpd || wrap) begin
        arrAct <= arrShadowNxt;
        cmpAct <= cmpShadowNxt;
      end else if (cmpWr && !preloadOn) begin
        cmpAct <= wrData;
      end

      if (ctrl.forceUpd)  cnt <= '0;
      else if (wrap)      cnt <= '0;
      else if (ctrl.run)  cnt <= cnt + 1'b1;

      updateFlag <= ctrl.forceUpd || wrap;
    end
  end

  // polarity is applied after the active/inactive decision
  assign refActive = ctrl.run && (cnt < cmpAct);
  assign pwmOut    = outEn ? (refActive ^ polLow) : polLow;
endmodule

// File: rtl/pwm_burst_ctrl.sv
`timescale 1ns/1ps
module pwm_burst_ctrl
  import pwm_burst_pkg::*;
#(
  parameter int PULSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               swUpdate,
  input  logic               wrap,
  input  logic [PULSE_W-1:0] pulseCfg,
  output ctrlStrobe_t        ctrl,
  output logic [PULSE_W-1:0] remain,
  output logic               done
);
  logic running;
  logic startOk;
  logic lastWrap;

  assign startOk  = start && !running && (pulseCfg != '0);
  assign lastWrap = running && wrap && !swUpdate && (remain == PULSE_W'(1));

  assign ctrl.forceUpd = startOk || swUpdate;
  assign ctrl.run      = running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      remain  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (startOk) begin
        running <= 1'b1;
        remain  <= pulseCfg;
      end else if (running && wrap && !swUpdate) begin
        remain <= remain - 1'b1;
        if (lastWrap) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_burst_gen.sv
`timescale 1ns/1ps
module pwm_burst_gen
  import pwm_burst_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             start,
  input  logic             swUpdate,
  output logic             pwmOut,
  output logic             running,
  output logic             done,
  output logic             updateFlag
);
  ctrlStrobe_t        ctrlS;
  logic               wrap;
  logic [PULSE_W-1:0] pulseCfg;
  logic [PULSE_W-1:0] remain;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cmpAct;
  logic               preloadOn;
  logic               polLow;

  pwm_burst_ctrl #(.PULSE_W(PULSE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .swUpdate(swUpdate),
    .wrap(wrap), .pulseCfg(pulseCfg), .ctrl(ctrlS), .remain(remain),
    .done(done)
  );

  pwm_burst_dp #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ctrl(ctrlS), .wrap(wrap), .pulseCfg(pulseCfg),
    .cnt(cnt), .cmpAct(cmpAct), .preloadOn(preloadOn), .polLow(polLow),
    .pwmOut(pwmOut), .updateFlag(updateFlag)
  );

  assign running = ctrlS.run;
endmodule

// File: rtl/pwm_burst_chk.sv
`timescale 1ns/1ps
module pwm_burst_chk #(
  parameter int CNT_W   = 16,
  parameter int PULSE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               swUpdate,
  input logic               running,
  input logic               done,
  input logic               pwmOut,
  input logic               wrap,
  input logic               forceUpd,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   cmpAct,
  input logic               preloadOn,
  input logic               polLow,
  input logic [PULSE_W-1:0] remain
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running && !wrap && !forceUpd |=> cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1});

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !forceUpd |=> cnt == '0);

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> pwmOut == polLow);

  p_cmp_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    preloadOn && !forceUpd && !wrap |=> $stable(cmpAct));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running && start && !swUpdate && !wrap |=> running && $stable(remain));

  p_force_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    forceUpd |=> cnt == '0);
endmodule

bind pwm_burst_gen pwm_burst_chk #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .swUpdate(swUpdate),
  .running(running), .done(done), .pwmOut(pwmOut), .wrap(wrap),
  .forceUpd(ctrlS.forceUpd), .cnt(cnt), .cmpAct(cmpAct),
  .preloadOn(preloadOn), .polLow(polLow), .remain(remain)
);

// File: tb/pwm_burst_gen_tb.sv
`timescale 1ns/1ps
module pwm_burst_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PULSE_W    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic             start = 1'b0;
  logic             swUpdate = 1'b0;
  logic             pwmOut, running, done, updateFlag;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  // burst parameters
  int bP, bC1, bC2, bN, bTw, bTs, bTi;
  bit bPol, bEn, bPre;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_burst_gen #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .swUpdate(swUpdate), .pwmOut(pwmOut), .running(running),
    .done(done), .updateFlag(updateFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int cmpAt(int t);
    if (bTw < 0) return bC1;
    if (!bPre) return (t >= bTw + 1) ? bC2 : bC1;
    if (bTs >= 0) return (t >= bTs + 1) ? bC2 : bC1;
    return (t >= bP + 1) ? bC2 : bC1;
  endfunction

  function automatic bit expPwm(int t, int endT);
    int u, ph;
    bit act;
    if (t >= endT) return bPol;
    u  = (bTs >= 0 && t >= bTs + 1) ? t - bTs - 1 : t;
    ph = u % (bP + 1);
    act = (ph < cmpAt(t));
    return bEn ? (act ^ bPol) : bPol;
  endfunction

  function automatic bit expFlag(int t);
    int s;
    s = (bTs >= 0) ? bTs + 1 : 0;
    if (t == 0) return 1'b1;
    if (bTs >= 0 && t == bTs + 1) return 1'b1;
    return (t > s) && ((t - s) % (bP + 1) == 0);
  endfunction

  task automatic runBurst(input string req);
    int endT, pwmBad, flagBad, doneBad, firstT;
    int aPwm, ePwm;
    regWrite(2'd2, int'(bPol) | (int'(bPre) << 1) | (int'(bEn) << 2));
    regWrite(2'd0, bP);
    regWrite(2'd1, bC1);
    regWrite(2'd3, bN);
    endT = (bTs >= 0) ? bTs + 1 + bN * (bP + 1) : bN * (bP + 1);
    pwmBad = 0; flagBad = 0; doneBad = 0; firstT = -1; aPwm = 0; ePwm = 0;
    start = 1'b1;
    for (int t = 0; t <= endT; t++) begin
      @(negedge clk);
      start = 1'b0; swUpdate = 1'b0; wrEn = 1'b0;
      if (pwmOut !== expPwm(t, endT)) begin
        if (pwmBad == 0) begin firstT = t; aPwm = int'(pwmOut); ePwm = int'(expPwm(t, endT)); end
        pwmBad++;
      end
      if (updateFlag !== expFlag(t)) flagBad++;
      if (done !== (t == endT) || running !== (t < endT)) doneBad++;
      if (t == bTw) begin wrEn = 1'b1; wrAddr = 2'd1; wrData = CNT_W'(bC2); end
      if (t == bTs) swUpdate = 1'b1;
      if (t == bTi) begin wrEn = 1'b1; wrAddr = 2'd3; wrData = CNT_W'(bN + 3); end
      if (bTi >= 0 && t == bTi + 1) start = 1'b1;
    end
    check(pwmBad == 0, req, $sformatf("pin pattern (first bad offset %0d)", firstT), aPwm, ePwm);
    check(flagBad == 0, "R1", "updateFlag mismatching cycles", flagBad, 0);
    check(doneBad == 0, "R6", "done/running mismatching cycles", doneBad, 0);
    @(negedge clk);
    check(done == 1'b0 && pwmOut == bPol, "R6", "done dropped, idle pin",
          int'({done, pwmOut}), int'({1'b0, bPol}));
  endtask

  task automatic setBurst(int p, int c1, int c2, int n, bit pol, bit en, bit pre,
                          int tw, int ts, int ti);
    bP = p; bC1 = c1; bC2 = c2; bN = n; bPol = pol; bEn = en; bPre = pre;
    bTw = tw; bTs = ts; bTi = ti;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0b17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R3, R6)
    check(pwmOut == 1'b0 && running == 1'b0 && done == 1'b0 && updateFlag == 1'b0,
          "R3", "reset outputs", int'({pwmOut, running, done, updateFlag}), 0);

    // idle with active-low polarity, output disabled then enabled (R3)
    regWrite(2'd2, 1);
    check(pwmOut == 1'b1, "R3", "idle pin, disabled, active-low", int'(pwmOut), 1);
    regWrite(2'd2, 5);
    check(pwmOut == 1'b1, "R3", "idle pin, enabled, active-low", int'(pwmOut), 1);

    // zero pulse count start ignored (R7)
    regWrite(2'd3, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(running == 1'b0 && updateFlag == 1'b0, "R7", "start with zero count",
          int'({running, updateFlag}), 0);
    repeat (3) @(negedge clk);
    check(running == 1'b0 && done == 1'b0, "R7", "still idle after zero-count start",
          int'({running, done}), 0);

    // zero compare, active-low: pin constant 1 (R2)
    setBurst(5, 0, 0, 3, 1, 1, 0, -1, -1, -1); runBurst("R2");
    // compare above reload: always active (R2)
    setBurst(4, 9, 9, 2, 0, 1, 0, -1, -1, -1); runBurst("R2");
    // output disabled during burst (R3)
    setBurst(3, 2, 2, 2, 1, 0, 0, -1, -1, -1); runBurst("R3");
    // half duty (R1, R5)
    setBurst(9, 5, 5, 4, 0, 1, 0, -1, -1, -1); runBurst("R5");
    // preloaded compare write mid-period (R4)
    setBurst(7, 2, 5, 3, 0, 1, 1, 3, -1, -1); runBurst("R4");
    // direct compare write mid-period (R4)
    setBurst(7, 2, 5, 3, 1, 1, 0, 3, -1, -1); runBurst("R4");
    // forced update applies held compare, restarts period (R8)
    setBurst(9, 3, 6, 2, 0, 1, 1, 2, 5, -1); runBurst("R8");
    // start during burst ignored (R7)
    setBurst(4, 2, 2, 3, 0, 1, 0, -1, -1, 6); runBurst("R7");

    // constrained random bursts (R1, R2, R3, R5, R6)
    for (int i = 0; i < 16; i++) begin
      int p, c;
      p = 1 + int'($urandom % 12);
      c = int'($urandom % (p + 3));
      setBurst(p, c, c, 1 + int'($urandom % 4), 1'($urandom), 1'($urandom),
               1'($urandom), -1, -1, -1);
      runBurst("R2");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule